// File: doc/BRIEF.md
# Switch Port-Group Forwarding Resolver

This block decides where each frame goes in a small Ethernet switch with twelve front ports (ports 0 to 11) and one CPU port (port 12). It holds a table of port-group masks, 92 entries of 13 bits each, where bit j stands for port j. Software fills the table through a plain write port and reads it back through a registered read port. Entries 0 to 11 are, by convention, single-port groups. Entries 12 to 63 are multi-port groups. Entry 80+i is the source mask of ingress port i: it lists the ports to which port i may forward.

For each frame, the block receives the ingress port, the result of the address lookup (hit flag, entry type, destination index, CPU queue) and the frame class. The destination mask comes from the entry at the destination index when the lookup hit. On a miss it comes from one of two flood entries, chosen by class. The front-port set is the destination mask ANDed with the ingress port's source mask, with the ingress port removed. The CPU receives a copy in two cases. The first is a hit of entry type 0 or 1 whose destination mask has the CPU bit set; in that case the source mask is bypassed. The second is any case where the CPU bit survives the AND.

Frames pass through a two-stage pipeline that has valid/ready handshakes on both sides.

Top module: `pgfr_top`

## Requirements
- R1: After reset every table entry reads as zero. A write at an index below 92 stores the 13-bit value, and a read of that index returns it on `cfg_rdata` one cycle after `cfg_raddr` is presented.
- R2: A read at an index of 92 or above returns zero. A write at such an index changes no entry.
- R3: On a hit (`in_hit`=1), the destination mask is the table entry at `in_dest_idx`. An out-of-range index gives an all-zero mask.
- R4: On a miss, the destination mask is the entry at `flood_uc_idx` when `in_class` is 0 (unicast). For any other class code (1 multicast, 2 broadcast), it is the entry at `flood_mc_idx`.
- R5: Bit p of `out_mask`, for front port p, is set only if bit p is set both in the destination mask and in the source mask at entry 80+`in_src`.
- R6: Bit `in_src` of `out_mask` is always zero.
- R7: When `in_hit`=1, `in_etype` is 0 or 1, and bit 12 of the destination mask is set, `out_cpu_copy` is 1 and `out_cpu_q` equals `in_cpu_q`, whatever the source mask holds.
- R8: In every other case, `out_cpu_copy` equals bit 12 of (destination mask AND source mask), and `out_cpu_q` is 0.
- R9: A frame accepted on a rising edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid`=1 after the next rising edge. While `out_valid`=1 and `out_ready`=0, the outputs hold and `in_ready` is 0.
- R10: A table write on the same edge that accepts a frame does not affect that frame. It does affect frames accepted on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_waddr | input | 7 | Table write index |
| cfg_wdata | input | 13 | Table write data, bit j = port j |
| cfg_raddr | input | 7 | Table read index |
| cfg_rdata | output | 13 | Registered table read data |
| flood_uc_idx | input | 7 | Flood entry for unicast misses |
| flood_mc_idx | input | 7 | Flood entry for multicast/broadcast misses |
| in_valid | input | 1 | Frame request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_src | input | 4 | Ingress port |
| in_hit | input | 1 | Address lookup hit |
| in_etype | input | 2 | Entry type of the matching address entry |
| in_dest_idx | input | 7 | Destination index of the matching entry |
| in_cpu_q | input | 3 | CPU queue field of the matching entry |
| in_class | input | 2 | 0 unicast, 1 multicast, 2 broadcast |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_mask | output | 12 | Egress front-port set |
| out_cpu_copy | output | 1 | Frame goes to the CPU |
| out_cpu_q | output | 3 | CPU queue for the copy |

## Verification
On every cycle, the assertions check four things: that the ingress port is missing from the result, that the front-port set stays inside the destination mask, that a nonzero queue only ever comes with a CPU copy, and that outputs hold steady while the downstream stalls. Out-of-range reads are also checked to return zero. Other behaviours can only be shown by the bench's scenarios. These are the choice between flood and hit entries by class, the CPU bypass for entry types 0 and 1 as opposed to types 2 and 3, the fact that out-of-range writes leave aliased entries untouched, and the ordering of a table write against a frame accepted on the same edge.

// File: rtl/pgfr_pkg.sv
package pgfr_pkg;
    localparam int FRONT_PORTS = 12;
    localparam int NPORTS      = FRONT_PORTS + 1;
    localparam int CPU_PORT    = FRONT_PORTS;
    localparam int TBL_DEPTH   = 92;
    localparam int SRC_BASE    = 80;
    localparam int IDX_W       = $clog2(TBL_DEPTH + 16);
    localparam int SRC_W       = $clog2(FRONT_PORTS + 4);
    localparam int Q_W         = 3;

    typedef logic [NPORTS-1:0]      pmask_t;
    typedef logic [FRONT_PORTS-1:0] fmask_t;
    typedef logic [IDX_W-1:0]       idx_t;
    typedef logic [SRC_W-1:0]       src_t;
    typedef logic [Q_W-1:0]         queue_t;

    typedef enum logic [1:0] {
        FC_UC = 2'd0,
        FC_MC = 2'd1,
        FC_BC = 2'd2,
        FC_RS = 2'd3
    } fclass_t;

    typedef struct packed {
        logic    hit;
        logic [1:0] etype;
        idx_t    didx;
        src_t    src;
        queue_t  q;
        fclass_t cls;
    } req_t;

    typedef struct packed {
        pmask_t  dmask;
        pmask_t  smask;
        logic    hit;
        logic [1:0] etype;
        src_t    src;
        queue_t  q;
    } stage_t;

    function automatic idx_t pick_dest(req_t r, idx_t uc, idx_t mc);
        if (r.hit)            return r.didx;
        else if (r.cls == FC_UC) return uc;
        else                  return mc;
    endfunction

    function automatic idx_t src_entry(src_t s);
        return idx_t'(SRC_BASE) + idx_t'(s);
    endfunction

    function automatic logic bypass_type(logic [1:0] et);
        return (et == 2'd0) || (et == 2'd1);
    endfunction
endpackage

// File: rtl/pgfr_table.sv
module pgfr_table
    import pgfr_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH,
    parameter int W     = NPORTS,
    parameter int AW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] cfg_raddr,
    output logic [W-1:0]  cfg_rdata,
    input  logic [AW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_idx,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] mem [DEPTH];

    function automatic logic in_range(logic [AW-1:0] a);
        return int'(a) < DEPTH;
    endfunction

    function automatic logic [W-1:0] rd(logic [AW-1:0] a);
        if (in_range(a)) return mem[a];
        else             return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && in_range(waddr)) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_rdata <= '0;
        else     cfg_rdata <= rd(cfg_raddr);
    end

    always_comb begin
        ra_data = rd(ra_idx);
        rb_data = rd(rb_idx);
    end

    // R2
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg_raddr) >= DEPTH) |=> (cfg_rdata == '0));
endmodule

// File: rtl/pgfr_lookup.sv
module pgfr_lookup
    import pgfr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld,
    input  req_t   req,
    input  idx_t   flood_uc,
    input  idx_t   flood_mc,
    output idx_t   d_idx,
    output idx_t   s_idx,
    input  pmask_t d_data,
    input  pmask_t s_data,
    output stage_t st
);
    always_comb begin
        d_idx = pick_dest(req, flood_uc, flood_mc);
        s_idx = src_entry(req.src);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (ld) begin
            st.dmask <= d_data;
            st.smask <= s_data;
            st.hit   <= req.hit;
            st.etype <= req.etype;
            st.src   <= req.src;
            st.q     <= req.q;
        end
    end
endmodule

// File: rtl/pgfr_combine.sv
module pgfr_combine
    import pgfr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld,
    input  stage_t st,
    output fmask_t front_q,
    output logic   cpu_q,
    output queue_t queue_q,
    output src_t   src_q
);
    pmask_t fwd;
    fmask_t front;
    logic   exc;

    assign fwd = st.dmask & st.smask;
    assign exc = st.hit && bypass_type(st.etype) && st.dmask[CPU_PORT];

    for (genvar p = 0; p < FRONT_PORTS; p++) begin : g_port
        assign front[p] = fwd[p] && (st.src != src_t'(p));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q <= '0;
            cpu_q   <= 1'b0;
            queue_q <= '0;
            src_q   <= '0;
        end else if (ld) begin
            front_q <= front;
            cpu_q   <= exc || fwd[CPU_PORT];
            queue_q <= exc ? st.q : '0;
            src_q   <= st.src;
        end
    end

    // R5
    dest_subset_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> ((front_q & ~$past(st.dmask[FRONT_PORTS-1:0])) == '0));
endmodule

// File: rtl/pgfr_top.sv
module pgfr_top
    import pgfr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_waddr,
    input  logic [NPORTS-1:0]      cfg_wdata,
    input  logic [IDX_W-1:0]       cfg_raddr,
    output logic [NPORTS-1:0]      cfg_rdata,
    input  logic [IDX_W-1:0]       flood_uc_idx,
    input  logic [IDX_W-1:0]       flood_mc_idx,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [SRC_W-1:0]       in_src,
    input  logic                   in_hit,
    input  logic [1:0]             in_etype,
    input  logic [IDX_W-1:0]       in_dest_idx,
    input  logic [Q_W-1:0]         in_cpu_q,
    input  logic [1:0]             in_class,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [FRONT_PORTS-1:0] out_mask,
    output logic                   out_cpu_copy,
    output logic [Q_W-1:0]         out_cpu_q
);
    logic   adv, s1_valid, ld1, ld2;
    req_t   req;
    idx_t   d_idx, s_idx;
    pmask_t d_data, s_data;
    stage_t st;
    src_t   out_src;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;
    assign ld1      = adv && in_valid;
    assign ld2      = adv && s1_valid;

    always_comb begin
        req.hit   = in_hit;
        req.etype = in_etype;
        req.didx  = in_dest_idx;
        req.src   = in_src;
        req.q     = in_cpu_q;
        req.cls   = fclass_t'(in_class);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else if (adv) begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    pgfr_table u_tbl (
        .clk(clk), .rst(rst),
        .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .ra_idx(d_idx), .ra_data(d_data),
        .rb_idx(s_idx), .rb_data(s_data)
    );

    pgfr_lookup u_lk (
        .clk(clk), .rst(rst), .ld(ld1), .req(req),
        .flood_uc(flood_uc_idx), .flood_mc(flood_mc_idx),
        .d_idx(d_idx), .s_idx(s_idx),
        .d_data(d_data), .s_data(s_data), .st(st)
    );

    pgfr_combine u_cb (
        .clk(clk), .rst(rst), .ld(ld2), .st(st),
        .front_q(out_mask), .cpu_q(out_cpu_copy),
        .queue_q(out_cpu_q), .src_q(out_src)
    );

    // R6
    no_ingress_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && (int'(out_src) < FRONT_PORTS) |-> !out_mask[out_src]);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_mask)
                                   && $stable(out_cpu_copy) && $stable(out_cpu_q));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R8
    queue_needs_copy_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_cpu_q != '0) |-> out_cpu_copy);
endmodule

// File: tb/sim_pgfr_top.sv
`timescale 1ns/1ps
module sim_pgfr_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [6:0]  cfg_waddr, cfg_raddr, flood_uc_idx, flood_mc_idx, in_dest_idx;
    logic [12:0] cfg_wdata, cfg_rdata;
    logic        in_valid, in_ready, in_hit, out_valid, out_ready, out_cpu_copy;
    logic [3:0]  in_src;
    logic [1:0]  in_etype, in_class;
    logic [2:0]  in_cpu_q, out_cpu_q;
    logic [11:0] out_mask;

    logic [12:0] shadow [92];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pgfr_top u0 (.*);

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] ent(int i);
        return (i < 92) ? shadow[i] : 13'd0;
    endfunction

    // expected result from the requirements
    function automatic logic [15:0] expect_res(bit hit, logic [1:0] et, int didx, int src,
                                               logic [1:0] cls, logic [2:0] q);
        logic [12:0] d, s, f;
        logic [11:0] m;
        bit exc, cp;
        logic [2:0] oq;
        int idx;
        idx = hit ? didx : ((cls == 2'd0) ? int'(flood_uc_idx) : int'(flood_mc_idx));
        d = ent(idx);
        s = ent(80 + src);
        f = d & s;
        m = f[11:0];
        if (src < 12) m[src] = 1'b0;
        exc = hit && (et <= 2'd1) && d[12];
        cp  = exc || f[12];
        oq  = exc ? q : 3'd0;
        return {m, cp, oq};
    endfunction

    task automatic tbl_write(int a, logic [12:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = 7'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 92) shadow[a] = v;
    endtask

    task automatic tbl_read(int a, string req);
        @(negedge clk);
        cfg_raddr = 7'(a);
        @(negedge clk);
        chk(cfg_rdata == ent(a), req, 32'(cfg_rdata), 32'(ent(a)));
    endtask

    task automatic drive(bit hit, logic [1:0] et, int didx, int src, logic [1:0] cls, logic [2:0] q);
        in_valid = 1'b1; in_hit = hit; in_etype = et; in_dest_idx = 7'(didx);
        in_src = 4'(src); in_class = cls; in_cpu_q = q;
    endtask

    task automatic send(bit hit, logic [1:0] et, int didx, int src, logic [1:0] cls,
                        logic [2:0] q, string req);
        logic [15:0] e;
        @(negedge clk);
        drive(hit, et, didx, src, cls, q);
        e = expect_res(hit, et, didx, src, cls, q);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b1, {req, " R9 valid"}, 32'(out_valid), 1);
        chk({out_mask, out_cpu_copy, out_cpu_q} == e, req,
            32'({out_mask, out_cpu_copy, out_cpu_q}), 32'(e));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] e_old, e_new, hold;
        int r;
        r = $urandom(32'd2024);
        for (int i = 0; i < 92; i++) shadow[i] = '0;
        rst = 1'b1; cfg_we = 0; cfg_waddr = 0; cfg_wdata = 0; cfg_raddr = 7'd5;
        flood_uc_idx = 7'd30; flood_mc_idx = 7'd31;
        in_valid = 0; in_hit = 0; in_etype = 0; in_dest_idx = 0; in_src = 0;
        in_class = 0; in_cpu_q = 0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R1
        chk(out_valid == 0, "R9 reset out_valid", 32'(out_valid), 0);
        chk(in_ready == 1, "R9 reset in_ready", 32'(in_ready), 1);
        chk(cfg_rdata == 0, "R1 reset entry", 32'(cfg_rdata), 0);
        tbl_read(85, "R1 reset entry 85");

        // R1 write/readback
        tbl_write(7, 13'h0080);
        tbl_read(7, "R1 readback");
        // R2 out of range write ignored, aliases untouched
        tbl_write(36, 13'h0A5A);
        tbl_write(100, 13'h1FFF);
        tbl_read(100, "R2 oor read zero");
        tbl_read(36, "R2 alias untouched");
        tbl_write(92, 13'h1234);
        tbl_read(92, "R2 oor 92 zero");

        // directed CPU copy cases
        tbl_write(20, 13'h1008);          // cpu + port3
        tbl_write(85, 13'h0028);          // src5: ports 3,5, no cpu
        send(1, 2'd0, 20, 5, 2'd0, 3'd6, "R7 hit type0 bypass");
        send(1, 2'd1, 20, 5, 2'd1, 3'd2, "R7 hit type1 bypass");
        send(1, 2'd2, 20, 5, 2'd0, 3'd6, "R8 hit type2 no bypass");
        send(1, 2'd3, 20, 5, 2'd0, 3'd6, "R8 hit type3 no bypass");
        send(1, 2'd0, 110, 5, 2'd0, 3'd6, "R3 oor dest zero");
        tbl_write(30, 13'h1022);          // flood uc: cpu,1,5
        tbl_write(31, 13'h0104);          // flood mc: 2,8
        send(0, 2'd0, 20, 5, 2'd0, 3'd4, "R8 flood cpu blocked");
        tbl_write(85, 13'h1026);          // src5: cpu,1,2,5
        send(0, 2'd0, 20, 5, 2'd0, 3'd4, "R8 flood cpu allowed R6");
        send(0, 2'd0, 20, 5, 2'd1, 3'd4, "R4 mc flood");
        send(0, 2'd0, 20, 5, 2'd2, 3'd4, "R4 bc flood");
        tbl_write(20, 13'h1FFF);
        tbl_write(85, 13'h1FFF);
        send(1, 2'd2, 20, 5, 2'd0, 3'd1, "R6 ingress cleared");

        // R10 write on the accepting edge
        tbl_write(22, 13'h0010);
        @(negedge clk);
        drive(1, 2'd2, 22, 5, 2'd0, 3'd0);
        e_old = expect_res(1, 2'd2, 22, 5, 2'd0, 3'd0);
        cfg_we = 1'b1; cfg_waddr = 7'd22; cfg_wdata = 13'h0200;
        @(negedge clk);
        cfg_we = 1'b0; shadow[22] = 13'h0200;
        e_new = expect_res(1, 2'd2, 22, 5, 2'd0, 3'd0);
        @(negedge clk);
        chk({out_mask, out_cpu_copy, out_cpu_q} == e_old, "R10 same-edge write old",
            32'({out_mask, out_cpu_copy, out_cpu_q}), 32'(e_old));
        @(negedge clk);
        chk({out_mask, out_cpu_copy, out_cpu_q} == e_new, "R10 next frame new",
            32'({out_mask, out_cpu_copy, out_cpu_q}), 32'(e_new));
        in_valid = 1'b0;
        repeat (2) @(negedge clk);

        // R9 backpressure
        out_ready = 1'b0;
        @(negedge clk);
        drive(1, 2'd2, 20, 3, 2'd0, 3'd0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1, "R9 stall valid", 32'(out_valid), 1);
        hold = {out_mask, out_cpu_copy, out_cpu_q};
        repeat (3) @(negedge clk);
        chk(out_valid == 1 && {out_mask, out_cpu_copy, out_cpu_q} == hold, "R9 stall hold",
            32'({out_mask, out_cpu_copy, out_cpu_q}), 32'(hold));
        chk(in_ready == 0, "R9 stall in_ready", 32'(in_ready), 0);
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 0, "R9 drain", 32'(out_valid), 0);

        // random traffic, R3 R4 R5 R6 R7 R8
        for (int blk = 0; blk < 6; blk++) begin
            for (int i = 0; i < 92; i++)
                if (($urandom % 3) != 0) tbl_write(i, 13'($urandom));
            flood_uc_idx = 7'($urandom % 96);
            flood_mc_idx = 7'($urandom % 96);
            for (int n = 0; n < 60; n++)
                send(1'($urandom), 2'($urandom), int'($urandom % 100), int'($urandom % 12),
                     2'($urandom), 3'($urandom), "R5 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule